// File: doc/BRIEF.md
# Lockable Timer-Watchdog Register Bank

This block holds the software-visible settings of a timer and watchdog unit behind a small synchronous register port. Six registers are decoded at even offsets from a base address: a byte-wide configuration register, a clock prescaler, a timer 0 value, a timer 0 control/status word, a watchdog count and a watchdog service match value. Apart from the configuration register, each is plain storage here. The counting logic that would use them sits elsewhere.

The configuration register carries sticky protection bits. Once software sets one, the matching register or registers stop accepting writes and read back a fixed filler pattern instead of their contents. Only a reset can clear these bits. The configuration register can also lock itself, which freezes its own clock-select and service-enable bits along with its lock bits. Two of its fields are driven out as registered control pins. One picks the watchdog clock source, and one enables the service-by-data-match method.

The port has no back-pressure. A write takes effect at the clock edge where `wr_en` is high. A read returns data on `rd_data` one cycle after `rd_en`, showing the register state from before any write in that same cycle. `rd_data` holds its value while `rd_en` is low.

Top module: `twd_lockbank`

## Requirements
- R1: Reset clears every register, including the configuration register, to 0. All registers are then unlocked, and both `wdog_clk_sel` and `svc_match_en` are 0.
- R2: Registers decode at byte addresses 0x20 (configuration), 0x22 (prescaler), 0x24 (timer 0), 0x26 (timer 0 control/status), 0x28 (watchdog count) and 0x2A (watchdog match). A read of any other address returns 0, and a write to any other address changes no register.
- R3: Configuration bit 0 locks the configuration register, bit 1 the prescaler, bit 2 timer 0 and bit 3 the watchdog count. A lock bit written to 1 stays 1 until reset, and writing 0 to it has no effect.
- R4: A write to a locked register is discarded, and its stored value is kept.
- R5: A read of a locked register returns 16'hA5A5.
- R6: Configuration bit 2 locks both the timer 0 register and the timer 0 control/status register.
- R7: While configuration bit 0 is set, writes to the configuration register are ignored entirely, including bits 5:4.
- R8: Configuration bits 15:6 always read as 0, whatever was written to them.
- R9: Configuration bit 4 drives `wdog_clk_sel` (0 selects the timer 0 output, 1 selects the prescaled slow clock). Bit 5 drives `svc_match_en`. Both pins follow the cycle after an accepted write.
- R10: `rd_data` is updated the cycle after `rd_en` with the pre-write state, and it holds when `rd_en` is low.
- R11: The watchdog match register is never locked and always accepts writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| wdog_clk_sel | output | 1 | Watchdog clock source select |
| svc_match_en | output | 1 | Service-by-data-match enable |

## Verification
Every cycle, the in-RTL properties check the following. Lock bits never fall. A locked register and a self-locked configuration register stay unchanged. Writes to undecoded addresses change nothing, and the match register always accepts writes. A locked read returns the filler pattern, and `rd_data` holds when idle. Only the bench scenarios can show the full address map and the reset values. They also cover lock sequences that combine several lock bits, including a lock set after data has been stored, and they check that a second reset releases every lock.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int NREG    = 6;
  localparam int CFG_W   = 6;
  localparam int LK_CFG  = 0;
  localparam int LK_PSC  = 1;
  localparam int LK_T0   = 2;
  localparam int LK_WCNT = 3;
  localparam int SEL_BIT = 4;
  localparam int SME_BIT = 5;

  typedef enum int {
    RI_CFG = 0, RI_PSC = 1, RI_T0 = 2, RI_T0CS = 3, RI_WCNT = 4, RI_WMATCH = 5
  } reg_idx_e;

  function automatic int lock_bit_of(int idx);
    case (idx)
      RI_CFG:           return LK_CFG;
      RI_PSC:           return LK_PSC;
      RI_T0, RI_T0CS:   return LK_T0;
      RI_WCNT:          return LK_WCNT;
      default:          return -1;
    endcase
  endfunction
endpackage

// File: rtl/twd_addr_decode.sv
module twd_addr_decode #(
  parameter int ADDR_W = 8,
  parameter int BASE   = 32,
  parameter int NREG   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(BASE + 2 * i);
    assign hit[i] = (addr == OFS);
  end
endmodule

// File: rtl/twd_cfg_reg.sv
module twd_cfg_reg
  import twd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q
);
  localparam int NLK = 4;
  logic self_lock;
  logic [CFG_W-1:0] cfg_d;

  assign self_lock = cfg_q[LK_CFG];

  always_comb begin
    cfg_d = cfg_q;
    if (we && !self_lock) begin
      cfg_d[NLK-1:0] = cfg_q[NLK-1:0] | wdata[NLK-1:0];
      cfg_d[SEL_BIT] = wdata[SEL_BIT];
      cfg_d[SME_BIT] = wdata[SME_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R3: lock bits never fall while out of reset
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cfg_q[NLK-1:0] & $past(cfg_q[NLK-1:0])) == $past(cfg_q[NLK-1:0])));
  // R7: self-locked configuration stays frozen
  p_self_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    self_lock |=> $stable(cfg_q));
endmodule

// File: rtl/twd_store_reg.sv
module twd_store_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         locked,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)              q <= '0;
    else if (we && !locked)  q <= wdata;
  end

  // R4: a locked register keeps its content
  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(q));
endmodule

// File: rtl/twd_read_mux.sv
module twd_read_mux #(
  parameter int              NREG    = 6,
  parameter int              DATA_W  = 16,
  parameter logic [DATA_W-1:0] PATTERN = 16'hA5A5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic [NREG-1:0]        hit,
  input  logic [NREG-1:0]        locked,
  input  logic [NREG*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]      rd_data
);
  logic [DATA_W-1:0] lane [NREG];
  logic [DATA_W-1:0] sel_d;
  logic              sel_locked;

  for (genvar i = 0; i < NREG; i++) begin : g_lane
    assign lane[i] = !hit[i] ? '0 :
                     (locked[i] ? PATTERN : regs_flat[i*DATA_W +: DATA_W]);
  end

  always_comb begin
    sel_d = '0;
    for (int i = 0; i < NREG; i++) sel_d = sel_d | lane[i];
  end

  assign sel_locked = |(hit & locked);

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= sel_d;
  end

  // R5: locked reads return the filler pattern
  p_locked_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_locked) |=> (rd_data == PATTERN));
  // R10: read data holds when idle
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/twd_lockbank.sv
module twd_lockbank
  import twd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BASE   = 32,
  parameter logic [DATA_W-1:0] PATTERN = 16'hA5A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              wdog_clk_sel,
  output logic              svc_match_en
);
  logic [NREG-1:0]        hit;
  logic [NREG-1:0]        locked;
  logic [CFG_W-1:0]       cfg_q;
  logic [NREG*DATA_W-1:0] regs_flat;

  twd_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NREG(NREG)) u_dec (
    .addr(bus_addr), .hit(hit)
  );

  twd_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(wr_en && hit[RI_CFG]),
    .wdata(wr_data[CFG_W-1:0]), .cfg_q(cfg_q)
  );

  assign regs_flat[RI_CFG*DATA_W +: DATA_W] = DATA_W'(cfg_q);

  for (genvar i = 0; i < NREG; i++) begin : g_lock
    localparam int LB = lock_bit_of(i);
    if (LB < 0) begin : g_open
      assign locked[i] = 1'b0;
    end else begin : g_gated
      assign locked[i] = cfg_q[LB];
    end
  end

  for (genvar i = 1; i < NREG; i++) begin : g_store
    twd_store_reg #(.W(DATA_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(wr_en && hit[i]), .locked(locked[i]),
      .wdata(wr_data), .q(regs_flat[i*DATA_W +: DATA_W])
    );
  end

  twd_read_mux #(.NREG(NREG), .DATA_W(DATA_W), .PATTERN(PATTERN)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .hit(hit), .locked(locked),
    .regs_flat(regs_flat), .rd_data(rd_data)
  );

  assign wdog_clk_sel = cfg_q[SEL_BIT];
  assign svc_match_en = cfg_q[SME_BIT];

  // R2: writes outside the map change nothing
  p_undecoded_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit == '0) |=> $stable(regs_flat));
  // R11: match register always accepts writes
  p_match_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit[RI_WMATCH]) |=> (regs_flat[RI_WMATCH*DATA_W +: DATA_W] == $past(wr_data)));
  // R9: clock select follows an accepted configuration write
  p_clk_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit[RI_CFG] && !cfg_q[LK_CFG]) |=> (wdog_clk_sel == $past(wr_data[SEL_BIT])));
  // R8: configuration reserved bits read back as zero
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit[RI_CFG] && !cfg_q[LK_CFG]) |=> (rd_data[DATA_W-1:CFG_W] == '0));
endmodule

// File: tb/tb_twd_lockbank.sv
module tb_twd_lockbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        wdog_clk_sel, svc_match_en;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [6];

  always #2 clk = ~clk;

  twd_lockbank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .wdog_clk_sel(wdog_clk_sel), .svc_match_en(svc_match_en)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 6; i++) model[i] = '0;
  endtask

  task automatic do_write(logic [7:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  function automatic logic [7:0] addr_of(int i);
    return 8'(32 + 2 * i);
  endfunction

  function automatic logic reg_locked(int i, logic [15:0] cfg);
    case (i)
      0: return cfg[0];
      1: return cfg[1];
      2, 3: return cfg[2];
      4: return cfg[3];
      default: return 1'b0;
    endcase
  endfunction

  // expected read of register i given the modeled state
  function automatic logic [15:0] exp_rd(int i);
    return reg_locked(i, model[0]) ? 16'hA5A5 : model[i];
  endfunction

  // configuration write per R3/R7/R8
  task automatic cfg_write(logic [15:0] d);
    do_write(addr_of(0), d);
    if (!model[0][0])
      model[0] = {10'd0, d[5:4], model[0][3:0] | d[3:0]};
  endtask

  task automatic plain_write(int i, logic [15:0] d);
    do_write(addr_of(i), d);
    if (!reg_locked(i, model[0])) model[i] = d;
  endtask

  task automatic check_all(string req);
    logic [15:0] v;
    for (int i = 0; i < 6; i++) begin
      do_read(addr_of(i), v);
      check(req, v, exp_rd(i));
    end
    check({req, "_sel"}, {15'd0, wdog_clk_sel}, {15'd0, model[0][4]});
    check({req, "_sme"}, {15'd0, svc_match_en}, {15'd0, model[0][5]});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    do_reset();
    // R1: reset state
    check_all("R1_reset");

    // R2: fill decoded registers, then sweep every address
    for (int i = 1; i < 6; i++) plain_write(i, 16'(16'h1100 * i + 16'h0033));
    for (int a = 0; a < 256; a++) begin
      if (a < 32 || a > 42 || (a % 2) == 1) begin
        do_write(8'(a), 16'hFFFF);
        do_read(8'(a), v);
        check("R2_undecoded_rd", v, 16'h0000);
      end
    end
    check_all("R2_map");

    // R10: read returns pre-write state when a write happens in the same cycle
    @(negedge clk); bus_addr = addr_of(5); wr_data = 16'h7E7E; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R10_prewrite", rd_data, model[5]);
    model[5] = 16'h7E7E;
    repeat (3) @(negedge clk);
    check("R10_hold", rd_data, 16'h5533);

    // R8/R9: reserved bits dropped, output pins follow
    for (int k = 0; k < 4; k++) begin
      cfg_write(16'hFFC0 | 16'(k << 4));
      check_all("R9_R8_cfg");
    end

    // R3/R4: prescaler lock, then attempt clear and overwrite
    cfg_write(16'h0012);
    plain_write(1, 16'h0BAD);
    check_all("R4_psc_locked");
    cfg_write(16'h0020);
    check_all("R3_sticky");

    // R6: timer 0 lock covers both timer registers
    plain_write(3, 16'h0C0C);
    cfg_write(16'h0004);
    plain_write(2, 16'h1234);
    plain_write(3, 16'h4321);
    check_all("R6_t0_pair");

    // R3/R11: watchdog count lock; match still writable
    cfg_write(16'h0008);
    plain_write(4, 16'h9999);
    plain_write(5, 16'h2468);
    check_all("R11_match_open");

    // R5/R7: self-lock, later writes ignored
    cfg_write(16'h0011);
    check_all("R5_locked_rd");
    cfg_write(16'h0020);
    check_all("R7_self_lock");

    // R1: second reset releases all locks and clears storage
    do_reset();
    check_all("R1_release");
    plain_write(1, 16'h0ABC);
    check_all("R1_unlocked_wr");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule